// File: doc/BRIEF.md
# Memory-Card Status and Insertion Interrupt Register Block

This block is a small board-level register file on a word-indexed register bus. Software reads it to learn the state of a memory-card socket. Two inputs come from the socket: a write-protect level and a card-insertion indication. Both inputs are asynchronous, so each passes through a flip-flop synchroniser before any logic uses it.

The status word carries two bits:

- **Write-protect bit.** It mirrors the synchronised write-protect level and follows it up and down.
- **Insertion bit.** It is sticky. The synchronised card-insertion signal sets it, and it stays set after that signal drops. Only this bit drives the interrupt output. Software clears it by writing a one to its position in the status word.

Three more indices return constants: an identification word, a zero word and a decode word. Writes to the constant indices are accepted and change nothing.

Reads are registered. The read strobe samples the index on a clock edge, and the read data port shows the result from that edge on. The read data port holds its value until the next read.

Top module: `card_status_regs`

## Requirements
- R1: After reset the status word, the interrupt output and the read data port are all zero.
- R2: A read of index 0 returns 0x41034003.
- R3: A read of index 1 returns 0x00000000, and a read of index 3 returns 0x00000011.
- R4: Status bit 0 (index 2) equals the write-protect input delayed by the two-stage synchroniser. It both sets and clears with that input.
- R5: Status bit 3 is set when the synchronised card-insertion input is high. It stays set after the input falls, including after a single-cycle pulse.
- R6: A write to index 2 clears status bit 3 only when write data bit 3 is 1. Bit 0 is not affected by the write, and every other status bit reads 0.
- R7: The interrupt output equals status bit 3 in every cycle. It rises when the bit is set and falls when the bit is cleared.
- R8: Writes to indices 0, 1 and 3 have no effect on the status word, the interrupt output or the constants read back.
- R9: When a clearing write to index 2 meets a synchronised card-insertion input that is still high, the set wins and bit 3 stays 1.
- R10: Read data updates on the edge that samples the read strobe, and it holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdEn | input | 1 | Read strobe, samples `addr` |
| wrEn | input | 1 | Write strobe, samples `addr` and `wrData` |
| addr | input | ADDR_W | Word index of the register |
| wrData | input | DATA_W | Write data |
| wpIn | input | 1 | Write-protect level from the socket, asynchronous |
| cardIn | input | 1 | Card-insertion indication, asynchronous |
| rdData | output | DATA_W | Registered read data |
| cardIrq | output | 1 | Card-insertion interrupt, equal to status bit 3 |

## Verification
The bound checker watches several properties on every cycle:

- the interrupt never rises unless the card-insertion input was high three cycles earlier;
- the interrupt never falls except after a clearing write;
- a clearing write against a still-high synchronised input leaves the interrupt set;
- writes to other indices never drop the interrupt;
- the read data port holds while no read is strobed;
- the identification word comes back on every read of index 0.

Some behaviour only the bench scenarios can show:

- the write-protect bit tracking its input in both directions through the synchroniser;
- the sticky capture of a one-cycle insertion pulse;
- a write whose bit 3 is zero leaving bit 3 in place;
- the exact status words read back after mixed sequences.

// File: rtl/card_status_pkg.sv
package card_status_pkg;

  localparam int IDX_IDENT  = 0;
  localparam int IDX_FLASH  = 1;
  localparam int IDX_STATUS = 2;
  localparam int IDX_DECODE = 3;

  typedef enum logic [2:0] {
    SEL_IDENT,
    SEL_FLASH,
    SEL_STATUS,
    SEL_DECODE,
    SEL_NONE
  } rdSel_e;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic   rdStrobe;
    rdSel_e rdSel;
    logic   ackCard;
  } ctrlStrobe_t;

endpackage

// File: rtl/card_status_sync.sv
module card_status_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/card_status_ctrl.sv
module card_status_ctrl
  import card_status_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 32,
  parameter int CARD_BIT = 3
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobe_t       strobe
);
  localparam logic [DATA_W-1:0] CARD_MASK = DATA_W'(1) << CARD_BIT;

  logic hitStatus;
  logic ackBit;

  assign hitStatus = (addr == ADDR_W'(IDX_STATUS));
  assign ackBit    = |(wrData & CARD_MASK);

  always_comb begin
    strobe.rdStrobe = rdEn;
    strobe.ackCard  = wrEn && hitStatus && ackBit;
    if (addr == ADDR_W'(IDX_IDENT))       strobe.rdSel = SEL_IDENT;
    else if (addr == ADDR_W'(IDX_FLASH))  strobe.rdSel = SEL_FLASH;
    else if (hitStatus)                   strobe.rdSel = SEL_STATUS;
    else if (addr == ADDR_W'(IDX_DECODE)) strobe.rdSel = SEL_DECODE;
    else                                  strobe.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/card_status_dp.sv
module card_status_dp
  import card_status_pkg::*;
#(
  parameter int                 DATA_W      = 32,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 WP_BIT      = 0,
  parameter int                 CARD_BIT    = 3,
  parameter logic [DATA_W-1:0]  IDENT_WORD  = 32'h4103_4003,
  parameter logic [DATA_W-1:0]  DECODE_WORD = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic              wpIn,
  input  logic              cardIn,
  output logic [DATA_W-1:0] rdData,
  output logic              cardIrq
);
  localparam int SYNC_W   = 2;
  localparam int SYNC_WP  = 0;
  localparam int SYNC_CRD = 1;

  logic [SYNC_W-1:0] syncLevels;
  logic              cardLatch;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] readMux;

  card_status_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn({cardIn, wpIn}),
    .syncOut(syncLevels)
  );

  // Sticky insertion bit: a set takes priority over an acknowledge
  always_ff @(posedge clk) begin
    if (rst) cardLatch <= 1'b0;
    else     cardLatch <= syncLevels[SYNC_CRD] | (cardLatch & ~strobe.ackCard);
  end

  always_comb begin
    statusWord           = '0;
    statusWord[WP_BIT]   = syncLevels[SYNC_WP];
    statusWord[CARD_BIT] = cardLatch;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_IDENT:  readMux = IDENT_WORD;
      SEL_STATUS: readMux = statusWord;
      SEL_DECODE: readMux = DECODE_WORD;
      default:    readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdData <= '0;
    else if (strobe.rdStrobe) rdData <= readMux;
  end

  assign cardIrq = cardLatch;
endmodule

// File: rtl/card_status_regs.sv
module card_status_regs
  import card_status_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int WP_BIT      = 0,
  parameter int CARD_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpIn,
  input  logic              cardIn,
  output logic [DATA_W-1:0] rdData,
  output logic              cardIrq
);
  ctrlStrobe_t strobe;

  card_status_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CARD_BIT(CARD_BIT)) u_ctrl (
    .rdEn  (rdEn),
    .wrEn  (wrEn),
    .addr  (addr),
    .wrData(wrData),
    .strobe(strobe)
  );

  card_status_dp #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES),
    .WP_BIT     (WP_BIT),
    .CARD_BIT   (CARD_BIT)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wpIn   (wpIn),
    .cardIn (cardIn),
    .rdData (rdData),
    .cardIrq(cardIrq)
  );
endmodule

// File: rtl/card_status_chk.sv
module card_status_chk #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 32,
  parameter int CARD_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              cardIn,
  input logic [DATA_W-1:0] rdData,
  input logic              cardIrq
);
  localparam logic [DATA_W-1:0] CARD_MASK = DATA_W'(1) << CARD_BIT;

  logic ackWrite;
  assign ackWrite = wrEn && (addr == ADDR_W'(2)) && (|(wrData & CARD_MASK));

  // R5 R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cardIrq) |-> $past(cardIn, 3));

  // R6 R7
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cardIrq) |-> $past(ackWrite));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ackWrite && $past(cardIn, 2)) |=> cardIrq);

  // R8
  other_write_keeps_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr != ADDR_W'(2) && cardIrq) |=> cardIrq);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

  // R2
  ident_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr == ADDR_W'(0)) |=> rdData == DATA_W'(32'h4103_4003));
endmodule

bind card_status_regs card_status_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CARD_BIT(CARD_BIT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rdEn   (rdEn),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .cardIn (cardIn),
  .rdData (rdData),
  .cardIrq(cardIrq)
);

// File: tb/test_card_status_regs.sv
`timescale 1ns/1ps
module test_card_status_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        wpIn = 1'b0;
  logic        cardIn = 1'b0;
  logic [31:0] rdData;
  logic        cardIrq;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  card_status_regs i_card_status_regs (
    .clk(clk), .rst(rst), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .wpIn(wpIn), .cardIn(cardIn),
    .rdData(rdData), .cardIrq(cardIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: issues a read and pushes the expected word for the monitor
  task automatic busRead(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // Monitor: pops and compares each read result one half-cycle after its edge
  initial forever begin
    @(posedge clk);
    if (rdEn && !rst) begin
      @(negedge clk);
      if (expQ.size() == 0) chk("R10 unexpected read", rdData, 32'hx);
      else chk(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    chk("R1 irq after reset", {31'b0, cardIrq}, 32'h0);
    chk("R1 rdData after reset", rdData, 32'h0);
    busRead(2, 32'h0, "R1 status after reset");

    busRead(0, 32'h4103_4003, "R2 ident word");
    busRead(1, 32'h0, "R3 index 1 zero");
    busRead(3, 32'h0000_0011, "R3 decode word");

    // R4 write-protect tracks its input both ways
    @(negedge clk); wpIn = 1'b1; idle(2);
    busRead(2, 32'h1, "R4 wp set");
    @(negedge clk); wpIn = 1'b0; idle(2);
    busRead(2, 32'h0, "R4 wp cleared");

    // R5 single-cycle pulse is captured and sticks
    @(negedge clk); cardIn = 1'b1;
    @(negedge clk); cardIn = 1'b0;
    idle(2);
    chk("R7 irq rises with bit 3", {31'b0, cardIrq}, 32'h1);
    busRead(2, 32'h8, "R5 sticky bit after pulse");

    // R6 write without bit 3 leaves the bit; bit 0 unaffected
    @(negedge clk); wpIn = 1'b1; idle(2);
    busWrite(2, 32'hFFFF_FFF7);
    chk("R6 irq kept by non-acking write", {31'b0, cardIrq}, 32'h1);
    busRead(2, 32'h9, "R6 status after non-acking write");

    // R8 writes to constant indices ignored
    busWrite(1, 32'hFFFF_FFFF);
    busWrite(3, 32'hFFFF_FFFF);
    busWrite(0, 32'hFFFF_FFFF);
    chk("R8 irq kept by ignored writes", {31'b0, cardIrq}, 32'h1);
    busRead(2, 32'h9, "R8 status after ignored writes");
    busRead(3, 32'h0000_0011, "R8 decode unchanged");
    busRead(0, 32'h4103_4003, "R8 ident unchanged");

    // R6 R7 acknowledge clears bit 3 only
    busWrite(2, 32'h8);
    chk("R7 irq falls on ack", {31'b0, cardIrq}, 32'h0);
    busRead(2, 32'h1, "R6 ack keeps bit 0");

    // R9 set wins over clear while input high
    @(negedge clk); cardIn = 1'b1; idle(3);
    chk("R9 irq set before ack", {31'b0, cardIrq}, 32'h1);
    busWrite(2, 32'h8);
    chk("R9 irq held through ack", {31'b0, cardIrq}, 32'h1);
    busRead(2, 32'h9, "R9 status after blocked ack");
    @(negedge clk); cardIn = 1'b0; idle(3);
    busWrite(2, 32'h8);
    chk("R6 ack after input low", {31'b0, cardIrq}, 32'h0);
    busRead(2, 32'h1, "R6 status after ack");

    // R10 read data holds while no read is strobed
    idle(4);
    chk("R10 rdData held", rdData, 32'h1);

    idle(2);
    if (expQ.size() != 0) chk("R10 pending reads", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule